// File: doc/BRIEF.md
# Memory Window Base Register with Size Probe

This block is one 32-bit memory-space base address register of the kind a PCI endpoint presents in its configuration header. Host software reaches it through a simple configuration write port with per-byte enables and a read-data port that always shows the current register word. The size of the memory window is a power-of-two parameter of at least 16 bytes. The window is always aligned to its own size.

Only the address bits at or above the window size can be written. The bits below that position read as zero. The four low information bits are fixed: a memory-space indicator, a 32-bit decoder type and a prefetchable flag set by a parameter. So when software writes all ones and reads the word back, it sees the size mask. It clears the four information bits, inverts the value and adds one, and the result is the window size in bytes. After software programs a base, the block compares incoming memory addresses with the writable base bits. It raises a hit while decoding is enabled and the address falls inside the window.

Top module: `membar_window`

## Requirements
- R1: Bit 0 of the read word is always 0, which marks a memory-space register.
- R2: Bits 2:1 of the read word are always 00, which marks a 32-bit decoder.
- R3: Bit 3 of the read word always equals the PREFETCH parameter, and no write changes it.
- R4: Bits from 4 up to REGION_LOG2-1 always read 0, whatever value is written.
- R5: After a full-word write of all ones, the read word is the size mask plus the prefetch bit. Clearing bits 3:0, inverting and adding one gives 2**REGION_LOG2.
- R6: After reset the base field, bits 31:4, reads as zero.
- R7: A configuration write changes only the bytes whose enable bit is set (cfg_be[n] covers bits 8n+7:8n). With no enable set, or no write strobe, the word is unchanged.
- R8: mem_hit is 1 when dec_en is 1 and mem_addr[31:REGION_LOG2] equals the programmed base bits. The first and last byte of the window hit, and the bytes just outside it miss.
- R9: mem_hit is 0 whenever dec_en is 0.
- R10: A write becomes visible on cfg_rdata after the clock edge that captures it. The hit decode uses the new base from that point on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current register word |
| dec_en | input | 1 | Memory decode enable |
| mem_addr | input | 32 | Incoming memory address |
| mem_hit | output | 1 | Address falls inside the programmed window |

## Verification
The assertions assume that the write strobe and byte enables are changed only away from the active clock edge. They also assume that reset is applied before the first checked cycle. The bench drives every input on the falling edge and starts with reset asserted, so both hold. Address probes are applied only while no write is in flight. This means each hit check sees a base value that is already stable.

// File: rtl/membar_pkg.sv
package membar_pkg;

  // Mask of the writable base bits for a window of 2**log2 bytes.
  function automatic logic [31:0] hi_mask(input int log2);
    hi_mask = 32'hFFFF_FFFF << log2;
  endfunction

  // Read word: stored base plus the fixed information nibble.
  // Bit 3 carries the prefetch flag; bits 2:0 are memory / 32-bit type.
  function automatic logic [31:0] read_word(input logic [31:0] base, input logic pf);
    read_word = {base[31:4], pf, 3'b000};
  endfunction

  // Window size recovered from a read word taken after an all-ones write.
  function automatic logic [31:0] size_from_probe(input logic [31:0] rd);
    size_from_probe = ~(rd & 32'hFFFF_FFF0) + 32'd1;
  endfunction

endpackage

// File: rtl/membar_store.sv
module membar_store #(
  parameter logic [31:0] WR_MASK = 32'hFFFF_F000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] base_q
);
  localparam int LANES = 4;

  logic [31:0] merged;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = be[g] ? wdata[8*g +: 8] : base_q[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en) begin
      base_q <= merged & WR_MASK;
    end
  end
endmodule

// File: rtl/membar_match.sv
module membar_match #(
  parameter logic [31:0] WR_MASK = 32'hFFFF_F000
) (
  input  logic [31:0] addr,
  input  logic [31:0] base,
  input  logic        en,
  output logic        hit
);
  logic in_window;

  assign in_window = ((addr ^ base) & WR_MASK) == 32'd0;
  assign hit       = en & in_window;
endmodule

// File: rtl/membar_window.sv
module membar_window #(
  parameter int REGION_LOG2 = 12,
  parameter bit PREFETCH    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        dec_en,
  input  logic [31:0] mem_addr,
  output logic        mem_hit
);
  localparam logic [31:0] WR_MASK = membar_pkg::hi_mask(REGION_LOG2);

  if (REGION_LOG2 < 4 || REGION_LOG2 > 31) begin : g_bad_size
    $error("REGION_LOG2 must lie in 4..31");
  end

  logic [31:0] base_q;

  membar_store #(.WR_MASK(WR_MASK)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .base_q (base_q)
  );

  membar_match #(.WR_MASK(WR_MASK)) i_match (
    .addr (mem_addr),
    .base (base_q),
    .en   (dec_en),
    .hit  (mem_hit)
  );

  assign cfg_rdata = membar_pkg::read_word(base_q, PREFETCH);
endmodule

// File: rtl/membar_checker.sv
module membar_checker #(
  parameter int REGION_LOG2 = 12,
  parameter bit PREFETCH    = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        dec_en,
  input logic [31:0] mem_addr,
  input logic        mem_hit
);
  localparam logic [31:0] HI_MASK  = 32'hFFFF_FFFF << REGION_LOG2;
  localparam logic [31:0] LOW_MASK = ~HI_MASK & 32'hFFFF_FFF0;

  p_mem_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] == 1'b0);

  p_dec32_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2:1] == 2'b00);

  p_pref_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] == PREFETCH);

  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & LOW_MASK) == 32'd0);

  p_reset_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_rdata[31:4] == 28'd0);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  p_top_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_be[3]) |=> $stable(cfg_rdata[31:24]));

  p_hit_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> ((mem_addr ^ cfg_rdata) & HI_MASK) == 32'd0);

  p_no_hit_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |-> !mem_hit);
endmodule

bind membar_window membar_checker #(
  .REGION_LOG2 (REGION_LOG2),
  .PREFETCH    (PREFETCH)
) i_membar_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_be    (cfg_be),
  .cfg_rdata (cfg_rdata),
  .dec_en    (dec_en),
  .mem_addr  (mem_addr),
  .mem_hit   (mem_hit)
);

// File: tb/test_membar_window.sv
module test_membar_window;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2 = 12;
  localparam int SIZE = 4096;

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // Applied in order from the reset state; expected word after each write.
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 32'hFFFF_FFFF, 32'hFFFF_F008},  // R4/R5 all ones
    '{4'hF, 32'h0000_0000, 32'h0000_0008},  // R3 zero write keeps bit 3
    '{4'hF, 32'h1234_5678, 32'h1234_5008},  // R4 low bits dropped
    '{4'h1, 32'hFFFF_FFFF, 32'h1234_5008},  // R4/R7 byte 0 has no writable bits
    '{4'h2, 32'h0000_AB00, 32'h1234_A008},  // R7 byte 1 only
    '{4'h8, 32'hCD00_0000, 32'hCD34_A008},  // R7 byte 3 only
    '{4'h4, 32'h00EF_0000, 32'hCDEF_A008},  // R7 byte 2 only
    '{4'h0, 32'hFFFF_FFFF, 32'hCDEF_A008},  // R7 no enables
    '{4'hF, 32'hA5A5_A5A5, 32'hA5A5_A008}   // R10 new base
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dec_en = 1'b0;
  logic [31:0] mem_addr = '0;
  logic        mem_hit;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  membar_window #(.REGION_LOG2(LOG2), .PREFETCH(1'b1)) i_membar_window (
    .clk, .rst_n, .cfg_wr, .cfg_be, .cfg_wdata, .cfg_rdata,
    .dec_en, .mem_addr, .mem_hit
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
  endtask

  task automatic probe(input string req, input logic en, input logic [31:0] a, input logic exp);
    dec_en = en; mem_addr = a;
    #1;
    check32(req, {31'd0, mem_hit}, {31'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check32("R6", {cfg_rdata[31:4], 4'h0}, 32'h0);
    check32("R1", {31'd0, cfg_rdata[0]}, 32'd0);
    check32("R2", {30'd0, cfg_rdata[2:1]}, 32'd0);
    check32("R3", {31'd0, cfg_rdata[3]}, 32'd1);
    probe("R8 base zero", 1'b1, 32'h0000_0FFF, 1'b1);

    for (int i = 0; i < NV; i++) begin
      write_reg(VECS[i].be, VECS[i].wd);
      check32("R4/R7/R10 vector", cfg_rdata, VECS[i].exp);
    end

    // Strobe low with enables set: no change
    @(negedge clk);
    cfg_be = 4'hF; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_be = '0;
    check32("R7 no strobe", cfg_rdata, 32'hA5A5_A008);

    // Window decode around base A5A5A000
    probe("R8 first byte", 1'b1, 32'hA5A5_A000, 1'b1);
    probe("R8 last byte",  1'b1, 32'hA5A5_AFFF, 1'b1);
    probe("R8 above",      1'b1, 32'hA5A5_B000, 1'b0);
    probe("R8 below",      1'b1, 32'hA5A5_9FFF, 1'b0);
    probe("R9 disabled",   1'b0, 32'hA5A5_A800, 1'b0);

    // Size probe
    write_reg(4'hF, 32'hFFFF_FFFF);
    check32("R5 size", ~(cfg_rdata & 32'hFFFF_FFF0) + 32'd1, SIZE);
    check32("R5 mask", cfg_rdata, 32'hFFFF_F008);
    probe("R10 hit after probe", 1'b1, 32'hFFFF_F123, 1'b1);
    probe("R10 old base misses", 1'b1, 32'hA5A5_A000, 1'b0);
    dec_en = 1'b0;

    // Mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check32("R6 re-reset", cfg_rdata, 32'h0000_0008);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule